// File: doc/BRIEF.md
# Serial Receiver with Frame-Sync Error Detection

This block is the receive half of a synchronous serial port. Everything runs on the receive bit clock. Each frame begins with an active-high frame-sync pulse. After a selectable delay of zero, one or two clock cycles, the block shifts a word in from the serial data line, most significant bit first. When the last bit arrives, the word is copied into a parallel read register and a ready flag is raised. A read strobe clears that flag.

The block also watches when each frame-sync pulse arrives. A pulse is early when the next frame's first data bit would land on or before the last bit of the word still in progress. An early pulse discards the partial word, starts a new frame from that pulse, and sets a sticky error flag. The flag stays set until an explicit clear or a reset. A longer data delay lets a legal pulse arrive earlier: with a delay of one, the pulse may share the edge of the last bit; with a delay of two, it may come on the edge of the bit before the last.

Top module: `rx_sync_receiver`

## Requirements
- R1: The first data bit is sampled on the rising edge that comes `dlySel` edges after the edge that samples frameSync high. The codes are 0, 1 and 2, and code 3 behaves as 2. The following WORD_LEN-1 edges sample the remaining bits.
- R2: A frameSync sampled at edge t is unexpected when t plus the delay is at or before the last-bit edge of the frame in progress. This includes a frame that is still in its delay phase. An unexpected frameSync sets syncErr at that edge.
- R3: After an unexpected frameSync, the partial word is never delivered and rxReady does not rise for it. A new frame starts from that pulse and delivers its own word normally.
- R4: At the edge that samples the last bit, the full word is copied to rxData and rxReady goes to 1.
- R5: Bits are shifted in MSB first: the first data bit sampled ends up in rxData[WORD_LEN-1].
- R6: A readStrobe sampled high clears rxReady at that edge, unless a word completes at the same edge.
- R7: syncErr stays set until errClear is sampled high. A new error at the same edge takes priority over errClear.
- R8: A frameSync that arrives while the receiver is idle, or exactly at the earliest legal edge, raises no error, and both words are delivered.
- R9: While rstN is low, rxData, rxReady and syncErr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rxClk | input | 1 | Receive bit clock; all sampling on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Active-high frame-sync pulse |
| serialIn | input | 1 | Serial data line |
| dlySel | input | 2 | Data delay select: 0, 1 or 2 cycles (3 acts as 2) |
| readStrobe | input | 1 | Read acknowledge; clears rxReady |
| errClear | input | 1 | Clears the sticky sync-error flag |
| rxData | output | WORD_LEN | Last completed word |
| rxReady | output | 1 | A new word is waiting in rxData |
| syncErr | output | 1 | Sticky flag: an unexpected frame-sync occurred |

## Verification
The bench builds the block with the default 8-bit word. With that width, the early-pulse boundaries fall at distinct bit positions for each delay: the pulse may come at the last bit for a delay of one, at the second-to-last bit for a delay of two, and only after the word for a delay of zero. The bench places pulses exactly on and one cycle before each boundary. It also places a pulse inside the delay phase of a frame that has not yet started. Each of these cases has a distinct expected outcome in syncErr, rxReady and rxData.

// File: rtl/rxsync_pkg.sv
package rxsync_pkg;
  // Strobes passed from the sequencing control to the datapath each cycle.
  typedef struct packed {
    logic shiftEn;   // sample serialIn into the shift register
    logic complete;  // this edge samples the last bit of a word
    logic setErr;    // an unexpected frame-sync was seen
  } rxStrobes_t;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rxsync_pkg::*;
#(
  parameter int WORD_LEN = 8
) (
  input  logic       rxClk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic [1:0] dlySel,
  output rxStrobes_t ctl
);
  localparam int CNT_W = $clog2(WORD_LEN + 1);
  localparam int REM_W = CNT_W + 1;

  // actRem: bits still to sample for the word in progress, counted from this edge.
  logic [CNT_W-1:0] actRem;
  // pendValid/pendCnt: a started frame still in its delay phase;
  // its first bit is sampled at the edge where pendCnt is 0.
  logic             pendValid;
  logic             pendCnt;
  logic [1:0]       effDelay;
  logic [REM_W-1:0] remCycles;
  logic             badSync;
  logic             firstPend;
  logic             startNow;

  always_comb begin
    effDelay  = (dlySel == 2'd3) ? 2'd2 : dlySel;
    // Edges from now up to and including the last bit of the newest frame.
    remCycles = pendValid ? (REM_W'(pendCnt) + REM_W'(WORD_LEN)) : REM_W'(actRem);
    badSync   = frameSync && (remCycles > REM_W'(effDelay));
    firstPend = pendValid && !pendCnt && !badSync;
    startNow  = frameSync && (effDelay == 2'd0);
    ctl.shiftEn  = ((actRem != '0) && !badSync) || firstPend || startNow;
    ctl.complete = (actRem == CNT_W'(1)) && !badSync;
    ctl.setErr   = badSync;
  end

  always_ff @(posedge rxClk or negedge rstN) begin
    if (!rstN) begin
      actRem    <= '0;
      pendValid <= 1'b0;
      pendCnt   <= 1'b0;
    end else begin
      if (badSync) begin
        actRem    <= '0;
        pendValid <= 1'b0;
      end else begin
        if (actRem != '0) actRem <= actRem - CNT_W'(1);
        if (pendValid) begin
          if (!pendCnt) begin
            pendValid <= 1'b0;
            actRem    <= CNT_W'(WORD_LEN - 1);
          end else begin
            pendCnt <= 1'b0;
          end
        end
      end
      if (frameSync) begin
        if (effDelay == 2'd0) begin
          actRem <= CNT_W'(WORD_LEN - 1);
        end else begin
          pendValid <= 1'b1;
          pendCnt   <= (effDelay == 2'd2);
        end
      end
    end
  end

  AST_IDLE_SYNC_OK: assert property (@(posedge rxClk) disable iff (!rstN)
    (frameSync && actRem == '0 && !pendValid) |-> !ctl.setErr); // R8
  AST_ABORT_NO_DELIVER: assert property (@(posedge rxClk) disable iff (!rstN)
    ctl.setErr |-> !ctl.complete); // R3
  AST_NO_OVERLAP_START: assert property (@(posedge rxClk) disable iff (!rstN)
    (pendValid && !pendCnt) |-> (actRem == '0)); // R1
endmodule

// File: rtl/rx_dpath.sv
module rx_dpath
  import rxsync_pkg::*;
#(
  parameter int WORD_LEN = 8
) (
  input  logic                rxClk,
  input  logic                rstN,
  input  logic                serialIn,
  input  logic                readStrobe,
  input  logic                errClear,
  input  rxStrobes_t          ctl,
  output logic [WORD_LEN-1:0] rxData,
  output logic                rxReady,
  output logic                syncErr
);
  logic [WORD_LEN-1:0] shiftReg;
  logic [WORD_LEN-1:0] shifted;

  // MSB first: older bits move toward the top.
  assign shifted = {shiftReg[WORD_LEN-2:0], serialIn};

  always_ff @(posedge rxClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      rxReady  <= 1'b0;
      syncErr  <= 1'b0;
    end else begin
      if (ctl.shiftEn) shiftReg <= shifted;
      if (ctl.complete) begin
        rxData  <= shifted;
        rxReady <= 1'b1;
      end else if (readStrobe) begin
        rxReady <= 1'b0;
      end
      if (ctl.setErr)    syncErr <= 1'b1;
      else if (errClear) syncErr <= 1'b0;
    end
  end

  AST_COMPLETE_SHIFTS: assert property (@(posedge rxClk) disable iff (!rstN)
    ctl.complete |-> ctl.shiftEn); // R4
  AST_COMPLETE_READY: assert property (@(posedge rxClk) disable iff (!rstN)
    ctl.complete |=> rxReady); // R4
  AST_READ_CLEARS: assert property (@(posedge rxClk) disable iff (!rstN)
    (readStrobe && !ctl.complete) |=> !rxReady); // R6
  AST_ERR_SETS: assert property (@(posedge rxClk) disable iff (!rstN)
    ctl.setErr |=> syncErr); // R2
  AST_ERR_STICKY: assert property (@(posedge rxClk) disable iff (!rstN)
    (syncErr && !errClear) |=> syncErr); // R7
  AST_DATA_HOLD: assert property (@(posedge rxClk) disable iff (!rstN)
    !ctl.complete |=> $stable(rxData)); // R4
endmodule

// File: rtl/rx_sync_receiver.sv
module rx_sync_receiver
  import rxsync_pkg::*;
#(
  parameter int WORD_LEN = 8
) (
  input  logic                rxClk,
  input  logic                rstN,
  input  logic                frameSync,
  input  logic                serialIn,
  input  logic [1:0]          dlySel,
  input  logic                readStrobe,
  input  logic                errClear,
  output logic [WORD_LEN-1:0] rxData,
  output logic                rxReady,
  output logic                syncErr
);
  initial begin
    assert (WORD_LEN >= 2) else $error("WORD_LEN must be at least 2");
  end

  rxStrobes_t ctl;

  rx_ctrl #(.WORD_LEN(WORD_LEN)) u_ctrl (
    .rxClk     (rxClk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .dlySel    (dlySel),
    .ctl       (ctl)
  );

  rx_dpath #(.WORD_LEN(WORD_LEN)) u_dpath (
    .rxClk      (rxClk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .readStrobe (readStrobe),
    .errClear   (errClear),
    .ctl        (ctl),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .syncErr    (syncErr)
  );
endmodule

// File: tb/test_rx_sync_receiver.sv
module test_rx_sync_receiver;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 6;
  // {delay code, word}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'h81},
    {2'd3, 8'h7E}, {2'd0, 8'h80}, {2'd2, 8'h01}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0, serialIn = 1'b0, readStrobe = 1'b0, errClear = 1'b0;
  logic [1:0] dlySel = 2'd0;
  logic [W-1:0] rxData;
  logic rxReady, syncErr;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_sync_receiver #(.WORD_LEN(W)) i_rx_sync_receiver (
    .rxClk(clk), .rstN(rstN), .frameSync(frameSync), .serialIn(serialIn),
    .dlySel(dlySel), .readStrobe(readStrobe), .errClear(errClear),
    .rxData(rxData), .rxReady(rxReady), .syncErr(syncErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one cycle from a negedge; returns at the following negedge.
  task automatic tick(input logic fs, input logic sd);
    frameSync = fs;
    serialIn  = sd;
    @(posedge clk);
    @(negedge clk);
    frameSync = 1'b0;
  endtask

  task automatic sendFrame(input int d, input logic [W-1:0] w);
    tick(1'b1, (d == 0) ? w[W-1] : 1'b0);
    for (int k = 1; k < d + W; k++) begin
      if (k >= d) tick(1'b0, w[W-1-(k-d)]);
      else        tick(1'b0, 1'b0);
    end
  endtask

  task automatic readOut();
    readStrobe = 1'b1;
    tick(1'b0, 1'b0);
    readStrobe = 1'b0;
  endtask

  task automatic clearErr();
    errClear = 1'b1;
    tick(1'b0, 1'b0);
    errClear = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    repeat (3) @(negedge clk);
    chk("R9 rxData", rxData, 0);
    chk("R9 rxReady", rxReady, 0);
    chk("R9 syncErr", syncErr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table of normal frames: R1 delay alignment, R4 copy, R5 MSB first.
    for (int i = 0; i < NVEC; i++) begin
      dlySel = VEC[i][9:8];
      sendFrame((VEC[i][9:8] == 2'd3) ? 2 : int'(VEC[i][9:8]), VEC[i][7:0]);
      chk("R1/R5 rxData", rxData, VEC[i][7:0]);
      chk("R4 rxReady", rxReady, 1);
      chk("R8 syncErr idle", syncErr, 0);
      readOut();
      chk("R6 read clears", rxReady, 0);
    end

    // R8: delay 1, next pulse on the last-bit edge is legal.
    a = 8'hA5; b = 8'h3C; dlySel = 2'd1;
    tick(1'b1, 1'b0);
    for (int i = 0; i < W - 1; i++) tick(1'b0, a[W-1-i]);
    tick(1'b1, a[0]);
    chk("R8 d1 first word", rxData, a);
    chk("R8 d1 no error", syncErr, 0);
    readStrobe = 1'b1;
    tick(1'b0, b[W-1]);
    readStrobe = 1'b0;
    for (int i = 1; i < W; i++) tick(1'b0, b[W-1-i]);
    chk("R8 d1 second word", rxData, b);
    chk("R8 d1 ready", rxReady, 1);
    chk("R8 d1 still no error", syncErr, 0);
    readOut();

    // R2/R3: delay 1, pulse one cycle too early.
    a = 8'h5A; b = 8'hC6;
    tick(1'b1, 1'b0);
    for (int i = 0; i < W - 2; i++) tick(1'b0, a[W-1-i]);
    tick(1'b1, a[1]);
    chk("R2 d1 early error", syncErr, 1);
    chk("R3 d1 no ready", rxReady, 0);
    for (int i = 0; i < W; i++) tick(1'b0, b[W-1-i]);
    chk("R3 d1 restart word", rxData, b);
    chk("R3 d1 ready", rxReady, 1);
    readOut();
    clearErr();
    chk("R7 clear", syncErr, 0);

    // R8: delay 2, pulse on the second-to-last bit edge is legal.
    a = 8'h96; b = 8'h69; dlySel = 2'd2;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < W - 2; i++) tick(1'b0, a[W-1-i]);
    tick(1'b1, a[1]);
    tick(1'b0, a[0]);
    chk("R8 d2 first word", rxData, a);
    chk("R8 d2 no error", syncErr, 0);
    readStrobe = 1'b1;
    tick(1'b0, b[W-1]);
    readStrobe = 1'b0;
    for (int i = 1; i < W; i++) tick(1'b0, b[W-1-i]);
    chk("R8 d2 second word", rxData, b);
    chk("R8 d2 still no error", syncErr, 0);
    readOut();

    // R2: delay 2, pulse one cycle too early.
    a = 8'hF0; b = 8'h0F;
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < W - 3; i++) tick(1'b0, a[W-1-i]);
    sendFrame(2, b);
    chk("R2 d2 early error", syncErr, 1);
    chk("R3 d2 restart word", rxData, b);
    readOut();
    clearErr();

    // R2/R3: delay 0, pulse mid-word.
    a = 8'hE1; b = 8'h1E; dlySel = 2'd0;
    tick(1'b1, a[7]); tick(1'b0, a[6]); tick(1'b0, a[5]);
    sendFrame(0, b);
    chk("R2 d0 mid-word error", syncErr, 1);
    chk("R3 d0 restart word", rxData, b);
    readOut();

    // R7: flag survives a good frame, then clears.
    dlySel = 2'd1;
    sendFrame(1, 8'h55);
    chk("R7 sticky after good frame", syncErr, 1);
    chk("R7 good frame data", rxData, 8'h55);
    readOut();
    clearErr();
    chk("R7 cleared", syncErr, 0);

    // R2: pulse during the delay phase of a frame not yet started.
    dlySel = 2'd2;
    tick(1'b1, 1'b0);
    sendFrame(2, 8'hC3);
    chk("R2 delay-phase error", syncErr, 1);
    chk("R3 delay-phase word", rxData, 8'hC3);

    // R7: new error at the same edge as errClear takes priority.
    readOut();
    clearErr();
    dlySel = 2'd0;
    tick(1'b1, 1'b1); tick(1'b0, 1'b0);
    errClear = 1'b1;
    tick(1'b1, 1'b0);
    errClear = 1'b0;
    chk("R7 set beats clear", syncErr, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule